// File: doc/BRIEF.md
# Infrared Carrier-Modulated Pulse Transmitter

This block turns a queue of mark and space durations into a waveform on a single infrared output pin. Software, or a neighbouring block, pushes duration words into a small transmit queue. The transmitter pops them one at a time and holds each level for the programmed length. A programmable prescaler divides the reference clock into ticks, and both interval durations and the carrier period are measured in those ticks. One divider setting therefore fixes both the time resolution of the pulse train and the carrier frequency.

With modulation on, a carrier burst is gated onto one of the two levels. The carrier period is sixteen ticks, and its high time is set in sixteenths of that period. A polarity control selects whether the burst goes on marks or on spaces. With modulation off, the pin simply reproduces the mark/space level. A service-request output, qualified by an interrupt enable, asks for a refill of the queue. The refill threshold is either half empty or fully empty.

Top module: `ir_tx_top`

## Requirements
- R1: While `tx_en` is high, the prescaler produces one tick every `divider`+1 clock cycles. A word with duration field c occupies exactly 4·c+4 ticks. Intervals start only on a tick and follow each other with no gap, so a run of words keeps `busy` high for the sum of (4·c+4)·(`divider`+1) cycles.
- R2: In a queue word, bits [15:0] are the duration field c and bit 16 is the level, where 1 means mark and 0 means space. With `mod_en` low, `ir_out` is high exactly during marks and low during spaces, whatever the value of `burst_on_space`.
- R3: With `mod_en` high, the carrier repeats every 16 ticks and is high for `duty`+1 of them. A bursting interval of 16·k ticks therefore drives `ir_out` high for k·(`duty`+1)·(`divider`+1) cycles.
- R4: With `burst_on_space` low, the burst goes on marks and spaces stay low. With it high, the burst goes on spaces and marks stay low.
- R5: The queue holds 8 words. A write made while it holds 8 words is discarded.
- R6: `svc_req` is high only while `tx_en` is high. With `svc_on_empty` low, it is high when the queue holds 4 words or fewer. With `svc_on_empty` high, it is high only when the queue is empty.
- R7: `irq` equals `svc_req` AND `irq_en`.
- R8: `busy` is high only while an interval is in progress. When the queue runs dry, `busy` falls and `ir_out` returns low.
- R9: When `tx_en` is low, `ir_out` and `busy` are low from the next clock edge on, and the queue is emptied. Writes made while `tx_en` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable; low flushes and idles |
| mod_en | input | 1 | Gate the carrier onto the bursting level |
| burst_on_space | input | 1 | Polarity: 1 moves the burst from marks to spaces |
| svc_on_empty | input | 1 | Refill threshold: 0 half empty, 1 empty |
| irq_en | input | 1 | Interrupt enable for the service request |
| divider | input | 16 | Tick period minus one, in clock cycles |
| duty | input | 4 | Carrier high time minus one, in ticks of 16 |
| wr_valid | input | 1 | Write strobe for a queue word |
| wr_data | input | 17 | Queue word: level at bit 16, duration at [15:0] |
| ir_out | output | 1 | Infrared output pin |
| busy | output | 1 | An interval is being sent |
| svc_req | output | 1 | Queue needs refilling |
| irq | output | 1 | Service request qualified by `irq_en` |

## Verification
The embedded assertions check the following on every cycle: the output is idle whenever no interval is active; disabling forces the pin and `busy` low on the next edge; the queue never exceeds its depth and keeps its count when a write hits a full queue; no pop occurs from an empty queue; the interrupt never rises without a service request; the pin stays low in unmodulated spaces. The exact tick arithmetic of intervals, the high time of each duty setting, the placement of the burst under each polarity, and the thresholds of the service request can only be shown by the bench. The bench does this by counting busy and high cycles over whole sequences and comparing them with closed-form sums.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;
  localparam int CAR_TICKS = 16;
  localparam int PH_W      = $clog2(CAR_TICKS);

  // carrier is high while the phase is within the duty window (duty+1 ticks)
  function automatic logic carrier_level(input logic [PH_W-1:0] phase,
                                         input logic [PH_W-1:0] duty);
    return phase <= duty;
  endfunction
endpackage

// File: rtl/ir_tx_prescaler.sv
module ir_tx_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R1: a nonzero divider never yields two ticks in a row
  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/ir_tx_fifo.sv
module ir_tx_fifo #(
  parameter int W     = 17,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign do_pop  = pop && (cnt_q != '0);
  assign do_push = push && (cnt_q != CNT_W'(DEPTH));
  assign rdata   = mem[rp_q];
  assign count   = cnt_q;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else if (flush) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= ptr_next(wp_q);
      if (do_pop)  rp_q <= ptr_next(rp_q);
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  // R5: occupancy bounded by the depth
  a_r5_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  // R5: a write into a full queue without a pop leaves it full
  a_r5_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(DEPTH) && push && !pop && !flush) |=> cnt_q == CNT_W'(DEPTH));
  // R8: the sequencer never pops an empty queue
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0);
endmodule

// File: rtl/ir_tx_carrier.sv
module ir_tx_carrier
  import ir_tx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            tick,
  input  logic [PH_W-1:0] duty,
  output logic            carrier
);
  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phase_q <= '0;
    else if (!run)  phase_q <= '0;
    else if (tick)  phase_q <= phase_q + 1'b1;
  end

  assign carrier = carrier_level(phase_q, duty);

  // R3: phase only moves on a tick
  a_r3_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (phase_q == $past(phase_q) || !run));
endmodule

// File: rtl/ir_tx_top.sv
module ir_tx_top
  import ir_tx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int DUR_W = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             mod_en,
  input  logic             burst_on_space,
  input  logic             svc_on_empty,
  input  logic             irq_en,
  input  logic [DIV_W-1:0] divider,
  input  logic [PH_W-1:0]  duty,
  input  logic             wr_valid,
  input  logic [DUR_W:0]   wr_data,
  output logic             ir_out,
  output logic             busy,
  output logic             svc_req,
  output logic             irq
);
  localparam int WORD_W = DUR_W + 1;
  localparam int REM_W  = DUR_W + 2;
  localparam int CNT_W  = $clog2(DEPTH+1);

  // reload value: duration field in quarter units plus the three hidden ticks
  function automatic logic [REM_W-1:0] interval_reload(input logic [DUR_W-1:0] c);
    return {c, 2'b11};
  endfunction

  logic              tick, carrier;
  logic [WORD_W-1:0] head;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              fifo_nonempty, load, drive;
  logic              busy_q, level_q, out_q;
  logic [REM_W-1:0]  rem_q;

  ir_tx_prescaler #(.DIV_W(DIV_W)) presc_i (
    .clk(clk), .rst_n(rst_n), .run(tx_en), .div(divider), .tick(tick)
  );

  ir_tx_carrier car_i (
    .clk(clk), .rst_n(rst_n), .run(tx_en), .tick(tick), .duty(duty),
    .carrier(carrier)
  );

  ir_tx_fifo #(.W(WORD_W), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .flush(!tx_en),
    .push(wr_valid && tx_en), .wdata(wr_data),
    .pop(load), .rdata(head), .count(fifo_cnt)
  );

  assign fifo_nonempty = (fifo_cnt != '0);
  assign load = tick && fifo_nonempty && (!busy_q || rem_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; level_q <= 1'b0; rem_q <= '0;
    end else if (!tx_en) begin
      busy_q <= 1'b0; level_q <= 1'b0; rem_q <= '0;
    end else if (tick) begin
      if (busy_q && rem_q != '0) begin
        rem_q <= rem_q - 1'b1;
      end else if (fifo_nonempty) begin
        busy_q  <= 1'b1;
        level_q <= head[DUR_W];
        rem_q   <= interval_reload(head[DUR_W-1:0]);
      end else begin
        busy_q  <= 1'b0;
        level_q <= 1'b0;
      end
    end
  end

  assign drive = mod_en ? ((level_q ^ burst_on_space) && carrier) : level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= tx_en && busy_q && drive;
  end

  assign ir_out  = out_q;
  assign busy    = busy_q;
  assign svc_req = tx_en && (svc_on_empty ? (fifo_cnt == '0)
                                          : (fifo_cnt <= CNT_W'(DEPTH/2)));
  assign irq     = svc_req && irq_en;

  // R8: no active interval means an idle pin on the next edge
  a_r8_idle_out: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> !ir_out);
  // R9: disabling idles pin and sequencer on the next edge
  a_r9_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!ir_out && !busy));
  // R7: interrupt only with a pending service request
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> svc_req);
  // R2: unmodulated spaces stay dark
  a_r2_space_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && busy_q && !mod_en && !level_q) |=> !ir_out);
  // R6: no service request while disabled
  a_r6_svc_off: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !svc_req);
endmodule

// File: tb/ir_tx_top_tb_top.sv
module ir_tx_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b0, mod_en = 1'b0, burst_on_space = 1'b0;
  logic        svc_on_empty = 1'b0, irq_en = 1'b0, wr_valid = 1'b0;
  logic [15:0] divider = 16'd1;
  logic [3:0]  duty = 4'd0;
  logic [16:0] wr_data = '0;
  logic        ir_out, busy, svc_req, irq;

  int n_chk = 0, n_fail = 0;
  logic meas = 1'b0, clr = 1'b0;
  int bc = 0, hc = 0;
  logic [16:0] wq [16];
  int nw = 0;

  always #5 clk = ~clk;

  ir_tx_top dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .mod_en(mod_en),
    .burst_on_space(burst_on_space), .svc_on_empty(svc_on_empty),
    .irq_en(irq_en), .divider(divider), .duty(duty),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .ir_out(ir_out), .busy(busy), .svc_req(svc_req), .irq(irq)
  );

  always @(posedge clk) begin
    if (clr) begin bc <= 0; hc <= 0; end
    else if (meas) begin bc <= bc + int'(busy); hc <= hc + int'(ir_out); end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FIFO-TX FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [16:0] mk(input logic mark, input int c);
    return {mark, 16'(c)};
  endfunction

  task automatic push(input logic [16:0] w);
    @(negedge clk); wr_valid = 1'b1; wr_data = w;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  // disable, configure, enable, push queue words, count over a window
  task automatic run_seq(input int d, input logic m, input logic p,
                         input int du, input int win);
    @(negedge clk); tx_en = 1'b0;
    repeat (2) @(negedge clk);
    divider = 16'(d); mod_en = m; burst_on_space = p; duty = 4'(du);
    clr = 1'b1;
    @(negedge clk); clr = 1'b0; meas = 1'b1; tx_en = 1'b1;
    for (int i = 0; i < nw; i++) push(wq[i]);
    repeat (win) @(negedge clk);
    meas = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++; n_chk++;
    $display("FIFO-TX FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state, R8 R6 R7
    chk("R8 reset ir_out", int'(ir_out), 0);
    chk("R8 reset busy", int'(busy), 0);
    chk("R6 reset svc_req", int'(svc_req), 0);
    chk("R7 reset irq", int'(irq), 0);
    rst_n = 1'b1;

    // R1 R2: interval arithmetic over several dividers, unmodulated
    wq[0] = mk(1, 0); wq[1] = mk(0, 1); wq[2] = mk(1, 3); wq[3] = mk(0, 2); nw = 4;
    foreach (wq[k]) if (k > 3) wq[k] = '0;
    for (int di = 0; di < 4; di++) begin
      int d;
      d = (di == 3) ? 5 : di;
      run_seq(d, 1'b0, 1'b0, 0, 40 * (d + 1) + 2 * (d + 1) + 30);
      chk("R1 busy cycles", bc, 40 * (d + 1));
      chk("R2 mark cycles", hc, 20 * (d + 1));
      chk("R8 idle after drain busy", int'(busy), 0);
      chk("R8 idle after drain out", int'(ir_out), 0);
    end
    // R2: polarity has no effect without modulation
    run_seq(1, 1'b0, 1'b1, 5, 120);
    chk("R2 polarity ignored unmodulated", hc, 40);

    // R3: duty sweep, mark and space of 16 ticks each
    wq[0] = mk(1, 3); wq[1] = mk(0, 3); nw = 2;
    for (int n = 0; n < 16; n++) begin
      run_seq(1, 1'b1, 1'b0, n, 100);
      chk("R3 carrier high cycles", hc, (n + 1) * 2);
      chk("R1 busy cycles modulated", bc, 64);
    end

    // R4: burst placement, mark of 32 ticks, space of 16 ticks
    wq[0] = mk(1, 7); wq[1] = mk(0, 3); nw = 2;
    run_seq(1, 1'b1, 1'b0, 3, 130);
    chk("R4 burst on marks", hc, 2 * 4 * 2);
    run_seq(1, 1'b1, 1'b1, 3, 130);
    chk("R4 burst on spaces", hc, 1 * 4 * 2);
    run_seq(2, 1'b1, 1'b1, 15, 190);
    chk("R4 full duty on spaces", hc, 16 * 3);

    // R5: ten writes into an 8-deep queue before the first tick
    for (int i = 0; i < 10; i++) wq[i] = mk(1, 0);
    nw = 10;
    run_seq(200, 1'b0, 1'b0, 0, 8 * 4 * 201 + 260);
    chk("R5 only 8 intervals sent", bc, 8 * 4 * 201);
    chk("R5 marks of dropped run", hc, 8 * 4 * 201);

    // R6 R7: thresholds, long divider so nothing is popped
    @(negedge clk); tx_en = 1'b0; divider = 16'd60000;
    svc_on_empty = 1'b0; irq_en = 1'b0;
    @(negedge clk); tx_en = 1'b1;
    @(negedge clk);
    chk("R6 half-empty threshold at 0", int'(svc_req), 1);
    for (int i = 1; i <= 9; i++) begin
      push(mk(1, 1));
      chk("R6 half-empty threshold", int'(svc_req), (i <= 4) ? 1 : 0);
    end
    @(negedge clk); svc_on_empty = 1'b1;
    @(negedge clk);
    chk("R6 empty threshold with full queue", int'(svc_req), 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R7 irq without request", int'(irq), 0);
    tx_en = 1'b0;
    @(negedge clk);
    chk("R6 no request while disabled", int'(svc_req), 0);
    // R9: writes while disabled are ignored
    push(mk(1, 1)); push(mk(1, 1));
    @(negedge clk); tx_en = 1'b1;
    @(negedge clk);
    chk("R9 flushed and writes ignored", int'(svc_req), 1);
    chk("R7 irq follows request", int'(irq), 1);
    irq_en = 1'b0;
    @(negedge clk);
    chk("R7 irq masked", int'(irq), 0);
    push(mk(1, 1));
    chk("R6 empty threshold with one word", int'(svc_req), 0);
    svc_on_empty = 1'b0;

    // R9: disable mid-interval
    wq[0] = mk(1, 100); nw = 1;
    @(negedge clk); tx_en = 1'b0;
    @(negedge clk); divider = 16'd1; mod_en = 1'b0; burst_on_space = 1'b0;
    @(negedge clk); tx_en = 1'b1;
    push(wq[0]);
    repeat (50) @(negedge clk);
    chk("R2 long mark high", int'(ir_out), 1);
    chk("R8 busy during mark", int'(busy), 1);
    tx_en = 1'b0;
    @(negedge clk);
    chk("R9 pin idle after disable", int'(ir_out), 0);
    chk("R9 busy cleared after disable", int'(busy), 0);
    @(negedge clk); tx_en = 1'b1;
    repeat (20) @(negedge clk);
    chk("R9 queue flushed no restart", int'(busy), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule